// File: doc/BRIEF.md
# Serial Bit-Addressed I/O Controller

This block moves between 1 and 16 bits over a single-bit serial I/O path, where every bit lives at its own address. A processor-side caller supplies a base bit address, a bit count, a direction and (for output) a data word, then pulses a start request. The block steps through consecutive bit addresses, spending exactly two clock cycles on each bit.

On an output transfer, each bit's address and data level are presented for a full two-cycle slot, and a one-cycle strobe fires in the second cycle of the slot. On an input transfer no strobe is produced at all. The block samples the serial input line at the end of each slot's second cycle and packs the bits into a result word. When the last slot ends, a one-cycle done pulse appears. A pointer step value tells the caller whether the transfer counted as a byte transfer (advance by 1) or a word transfer (advance by 2).

Top module: `bitio_ctrl`

## Requirements
- R1: After reset, busy, done and strobe are low, the result word is zero and the pointer step reads 1.
- R2: A start request seen while idle begins a transfer. Busy is high for exactly 2*N cycles for N bits. Done is high for exactly one cycle, the cycle right after the last busy cycle.
- R3: The count input is 4 bits wide. Values 1 to 15 select that many bits, and the value 0 selects 16 bits.
- R4: On an output transfer (direction input = 1), the strobe is low in the first cycle of each bit slot and high in the second. This gives exactly one single-cycle strobe per bit.
- R5: Bit k of a transfer uses bit address base+k, held through both cycles of its slot. Addresses wrap modulo 2^12.
- R6: Output bits are taken from the data word least significant bit first: bit k drives data out during slot k. The level is steady across the slot.
- R7: On an input transfer (direction input = 0), the strobe stays low throughout. The serial input is sampled at the clock edge that ends the second cycle of each slot. Bit k lands in result bit k, and result bits at N and above are zero.
- R8: The pointer step output is 1 for transfers of 1 to 8 bits and 2 for transfers of 9 to 16 bits. It holds from acceptance until the next accepted start.
- R9: A start request while busy is ignored. The running transfer keeps its count, addresses, data and direction.
- R10: An output transfer leaves the result word at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| base_addr_i | input | 12 | First bit address |
| count_i | input | 4 | Bit count, 0 meaning 16 |
| dir_out_i | input | 1 | 1 = output transfer, 0 = input transfer |
| wdata_i | input | 16 | Word to send, LSB first |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Assembled input bits |
| ptr_step_o | output | 2 | Caller pointer increment (1 or 2) |
| bit_addr_o | output | 12 | Current bit address |
| bit_dout_o | output | 1 | Current output bit level |
| bit_strobe_o | output | 1 | Per-bit output strobe |
| bit_din_i | input | 1 | Serial input line |

## Verification
Output transfers are run with counts of 1, 4, 8 and 16 (written as 0), using words whose low bits alternate irregularly. This separates LSB-first ordering from MSB-first and shows the 8/9 step boundary. Input transfers drive the inverse of the wanted bit in each slot's first cycle and the true bit in the second, so a sample taken one cycle early yields the complement. A base address near the top of the range exposes wrap handling. A second start is raised mid-transfer with different settings, and the strobe count and addresses must still match the first request.

// File: rtl/bitio_pkg.sv
package bitio_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bitio_state_e;

endpackage

// File: rtl/bitio_seq.sv
module bitio_seq
    import bitio_pkg::*;
#(
    parameter int unsigned MAX_BITS  = 16,
    parameter int unsigned BYTE_BITS = 8,
    localparam int unsigned CW       = $clog2(MAX_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] count_i,
    output logic          accept_o,
    output logic          run_o,
    output logic          phase_o,
    output logic          slot_end_o,
    output logic          advance_o,
    output logic [CW-1:0] idx_o,
    output logic          done_o,
    output logic          wide_o
);

    localparam logic [CW-1:0] BYTE_LIM = CW'(BYTE_BITS);

    typedef struct packed {
        bitio_state_e  state;
        logic          phase;
        logic [CW-1:0] idx;
        logic [CW-1:0] last_idx;
        logic          done;
        logic          wide;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;
    logic is_last;

    assign accept  = (s_q.state == ST_IDLE) && start_i;
    assign is_last = (s_q.idx == s_q.last_idx);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (accept) begin
            s_d.state    = ST_RUN;
            s_d.phase    = 1'b0;
            s_d.idx      = '0;
            // count of zero wraps to all ones: the full width
            s_d.last_idx = count_i - CW'(1);
            s_d.wide     = (count_i == '0) || (count_i > BYTE_LIM);
        end else if (s_q.state == ST_RUN) begin
            if (!s_q.phase) begin
                s_d.phase = 1'b1;
            end else begin
                s_d.phase = 1'b0;
                if (is_last) begin
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, phase: 1'b0, idx: '0, last_idx: '0,
                     done: 1'b0, wide: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign accept_o   = accept;
    assign run_o      = (s_q.state == ST_RUN);
    assign phase_o    = s_q.phase;
    assign slot_end_o = run_o && s_q.phase;
    assign advance_o  = slot_end_o && !is_last;
    assign idx_o      = s_q.idx;
    assign done_o     = s_q.done;
    assign wide_o     = s_q.wide;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_o) |-> done_o);

endmodule

// File: rtl/bitio_addr.sv
module bitio_addr #(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
    } addr_t;

    addr_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (load_i) begin
            a_d.addr = base_i;
        end else if (step_i) begin
            a_d.addr = a_q.addr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '{addr: '0};
        end else begin
            a_q <= a_d;
        end
    end

    assign addr_o = a_q.addr;

endmodule

// File: rtl/bitio_data.sv
module bitio_data #(
    parameter int unsigned MAX_BITS = 16,
    localparam int unsigned CW      = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [MAX_BITS-1:0] wdata_i,
    input  logic                dir_out_i,
    input  logic                run_i,
    input  logic                slot_end_i,
    input  logic [CW-1:0]       idx_i,
    input  logic                din_i,
    output logic                dir_o,
    output logic                dout_o,
    output logic [MAX_BITS-1:0] rdata_o
);

    typedef struct packed {
        logic [MAX_BITS-1:0] word;
        logic [MAX_BITS-1:0] res;
        logic                dir;
    } data_t;

    data_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (load_i) begin
            d_d.word = wdata_i;
            d_d.res  = '0;
            d_d.dir  = dir_out_i;
        end else if (slot_end_i && !d_q.dir) begin
            d_d.res[idx_i] = din_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '{word: '0, res: '0, dir: 1'b0};
        end else begin
            d_q <= d_d;
        end
    end

    assign dir_o   = d_q.dir;
    assign dout_o  = run_i && d_q.dir && d_q.word[idx_i];
    assign rdata_o = d_q.res;

endmodule

// File: rtl/bitio_ctrl.sv
module bitio_ctrl #(
    parameter int unsigned AW        = 12,
    parameter int unsigned MAX_BITS  = 16,
    parameter int unsigned BYTE_BITS = 8,
    localparam int unsigned CW       = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [AW-1:0]       base_addr_i,
    input  logic [CW-1:0]       count_i,
    input  logic                dir_out_i,
    input  logic [MAX_BITS-1:0] wdata_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [MAX_BITS-1:0] rdata_o,
    output logic [1:0]          ptr_step_o,
    output logic [AW-1:0]       bit_addr_o,
    output logic                bit_dout_o,
    output logic                bit_strobe_o,
    input  logic                bit_din_i
);

    logic          accept;
    logic          run;
    logic          phase;
    logic          slot_end;
    logic          advance;
    logic [CW-1:0] idx;
    logic          wide;
    logic          dir;

    bitio_seq #(
        .MAX_BITS (MAX_BITS),
        .BYTE_BITS(BYTE_BITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .count_i   (count_i),
        .accept_o  (accept),
        .run_o     (run),
        .phase_o   (phase),
        .slot_end_o(slot_end),
        .advance_o (advance),
        .idx_o     (idx),
        .done_o    (done_o),
        .wide_o    (wide)
    );

    bitio_addr #(
        .AW(AW)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(accept),
        .base_i(base_addr_i),
        .step_i(advance),
        .addr_o(bit_addr_o)
    );

    bitio_data #(
        .MAX_BITS(MAX_BITS)
    ) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .wdata_i   (wdata_i),
        .dir_out_i (dir_out_i),
        .run_i     (run),
        .slot_end_i(slot_end),
        .idx_i     (idx),
        .din_i     (bit_din_i),
        .dir_o     (dir),
        .dout_o    (bit_dout_o),
        .rdata_o   (rdata_o)
    );

    assign busy_o       = run;
    assign bit_strobe_o = run && phase && dir;
    assign ptr_step_o   = wide ? 2'd2 : 2'd1;

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe_o |=> !bit_strobe_o);

    // R5
    strobe_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe_o |-> $stable(bit_addr_o));

    // R6
    strobe_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe_o |-> $stable(bit_dout_o));

    // R2
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe_o |-> busy_o && !done_o);

endmodule

// File: tb/sim_bitio_ctrl.sv
`timescale 1ns/1ps
module sim_bitio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [11:0] base_addr_i = '0;
    logic [3:0]  count_i = '0;
    logic        dir_out_i = 1'b0;
    logic [15:0] wdata_i = '0;
    logic        busy_o, done_o, bit_dout_o, bit_strobe_o;
    logic [15:0] rdata_o;
    logic [1:0]  ptr_step_o;
    logic [11:0] bit_addr_o;
    logic        bit_din_i = 1'b0;

    int vectors = 0;
    int fails = 0;
    int strobes = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bitio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .count_i(count_i), .dir_out_i(dir_out_i), .wdata_i(wdata_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
        .ptr_step_o(ptr_step_o), .bit_addr_o(bit_addr_o),
        .bit_dout_o(bit_dout_o), .bit_strobe_o(bit_strobe_o),
        .bit_din_i(bit_din_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One transfer; word doubles as the input pattern for input transfers.
    task automatic run_xfer(input logic [11:0] base, input logic [3:0] cnt,
                            input logic out_dir, input logic [15:0] word,
                            input bit disturb);
        int n;
        logic [15:0] exp_res;
        n = (cnt == 4'd0) ? 16 : int'(cnt);
        exp_res = '0;
        strobes = 0;
        @(negedge clk);
        base_addr_i = base; count_i = cnt; dir_out_i = out_dir;
        wdata_i = word; start_i = 1'b1;
        @(negedge clk);
        if (disturb) begin
            // R9: different request held while busy
            base_addr_i = ~base; count_i = 4'd5; dir_out_i = ~out_dir; wdata_i = ~word;
        end else begin
            start_i = 1'b0;
        end
        for (int k = 0; k < n; k++) begin
            logic [11:0] ea;
            ea = base + 12'(k);
            check("R2 busy in slot", 32'(busy_o), 32'd1);
            check("R5 addr slot first cycle", 32'(bit_addr_o), 32'(ea));
            check(out_dir ? "R4 strobe low first cycle" : "R7 no strobe", 32'(bit_strobe_o), 32'd0);
            if (out_dir) check("R6 dout first cycle", 32'(bit_dout_o), 32'(word[k]));
            bit_din_i = ~word[k];
            if (disturb && k == 1) start_i = 1'b0;
            @(negedge clk);
            check("R5 addr slot second cycle", 32'(bit_addr_o), 32'(ea));
            check(out_dir ? "R4 strobe high second cycle" : "R7 no strobe", 32'(bit_strobe_o), 32'(out_dir));
            if (bit_strobe_o) strobes++;
            if (out_dir) check("R6 dout second cycle", 32'(bit_dout_o), 32'(word[k]));
            else exp_res[k] = word[k];
            bit_din_i = word[k];
            @(negedge clk);
        end
        check("R2 busy low at end", 32'(busy_o), 32'd0);
        check("R2 done pulse", 32'(done_o), 32'd1);
        check("R8 pointer step", 32'(ptr_step_o), (n <= 8) ? 32'd1 : 32'd2);
        check(out_dir ? "R10 result zero after output" : "R7 result LSB first",
              32'(rdata_o), 32'(exp_res));
        @(negedge clk);
        check("R2 done one cycle", 32'(done_o), 32'd0);
        check("R2 idle after done", 32'(busy_o), 32'd0);
    endtask

    task automatic t_reset;
        check("R1 busy", 32'(busy_o), 32'd0);
        check("R1 done", 32'(done_o), 32'd0);
        check("R1 strobe", 32'(bit_strobe_o), 32'd0);
        check("R1 result", 32'(rdata_o), 32'd0);
        check("R1 step", 32'(ptr_step_o), 32'd1);
    endtask

    task automatic t_out_byte;
        run_xfer(12'h100, 4'd8, 1'b1, 16'hA5C3, 1'b0);
        check("R4 strobe count 8", 32'(strobes), 32'd8);
    endtask

    task automatic t_out_full;
        run_xfer(12'h040, 4'd0, 1'b1, 16'h9E37, 1'b0);
        check("R3 count zero means 16", 32'(strobes), 32'd16);
    endtask

    task automatic t_out_single_and_wrap;
        run_xfer(12'h3A7, 4'd1, 1'b1, 16'hFFFF, 1'b0);
        check("R3 count one", 32'(strobes), 32'd1);
        run_xfer(12'hFFE, 4'd4, 1'b1, 16'h000A, 1'b0);
        check("R5 wrap strobes", 32'(strobes), 32'd4);
    endtask

    task automatic t_in_patterns;
        run_xfer(12'h200, 4'd5, 1'b0, 16'hFFF5, 1'b0);
        run_xfer(12'h010, 4'd9, 1'b0, 16'h0136, 1'b0);
        run_xfer(12'h7F0, 4'd0, 1'b0, 16'h6D2B, 1'b0);
        check("R7 no strobes on input", 32'(strobes), 32'd0);
    endtask

    task automatic t_out_after_in;
        run_xfer(12'h055, 4'd6, 1'b1, 16'h002D, 1'b0);
    endtask

    task automatic t_busy_ignore;
        run_xfer(12'h123, 4'd3, 1'b1, 16'h0005, 1'b1);
        check("R9 start while busy ignored", 32'(strobes), 32'd3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_out_byte;
        t_out_full;
        t_out_single_and_wrap;
        t_in_patterns;
        t_out_after_in;
        t_busy_ignore;
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule